// File: doc/BRIEF.md
# Shared Bus Ownership Arbiter

This block settles which on-chip requester may use a shared system bus. It handles three sources: a serial-channel DMA engine, a general-purpose DMA engine and an outside master. When the chip acts as a peripheral to an outside processor, the block obtains the external bus with a three-wire handshake. It pulls a request line low, waits for the grant line, and waits until the bus has gone quiet. It then holds its own acknowledge line low for the whole tenure. While the on-chip processor is enabled, the DMA engines are served directly. An outside master can also take the bus over with the halt line. The current owner then finishes its cycle, the bus drivers go to high impedance, and the outside master is handed the bus a fixed number of clocks after the address strobe has gone inactive.

All pin inputs from the outside bus are asynchronous. Each passes through a synchronizer chain before the state machine uses it. A DMA engine marks the end of its tenure with a one-cycle done pulse. The cycle-end input marks the end of any internal bus cycle, and the halt takeover uses it.

Top module: `bus_owner_arb`

## Requirements
- R1: After reset, busReqN and busAckN are high (inactive), grant is all zero, busOe is low in peripheral mode and extOwner is low.
- R2: The grant vector is one-hot, with bit 0 for the outside master, bit 1 for the serial-channel DMA and bit 2 for the general DMA. When requests are pending together at an arbitration point, the lowest bit index wins. An outside-master grant in peripheral mode is given on the clock after the request, without any external handshake.
- R3: With periphMode low, extMasterReq is ignored, busReqN stays high, and a DMA request is granted on the clock after it is seen.
- R4: In peripheral mode, a DMA request drives busReqN low on the next clock. No grant is given and busAckN stays high until busGrantN has been sampled low.
- R5: After busGrantN is seen low, the block waits until addrStrobeN, haltN and extAckN are all high. Only then does it drive busAckN low, raise the owner's grant bit and raise busOe.
- R6: In peripheral mode, one clock after the owner's done pulse, busAckN and busReqN go high, grant clears and busOe drops.
- R7: A request that arrives during a tenure does not change the owner. The grant never moves directly from one requester to another, and the waiting request is served at the next arbitration point.
- R8: At most one grant bit is high. No grant is high, and busOe is low, from the moment a halt takeover stops the owner until the takeover ends, even if other requests are pending.
- R9: With periphMode low and haltN low, the owner keeps its grant until cycleEnd or its done pulse. On the next clock, grant clears and busOe goes low.
- R10: During a halt takeover, extOwner rises on the fifth rising clock edge after addrStrobeN goes high. That is two synchronizer stages, one detection clock and HOLD_CLKS (default 2) extra clocks.
- R11: When haltN returns high, extOwner falls within three clocks and busOe is driven again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| periphMode | input | 1 | 1: on-chip processor disabled, chip acts as a peripheral |
| extMasterReq | input | 1 | Outside master wants the internal bus (peripheral mode only) |
| sdmaReq | input | 1 | Serial-channel DMA request |
| idmaReq | input | 1 | General DMA request |
| sdmaDone | input | 1 | One-cycle pulse: serial-channel DMA ended its last cycle |
| idmaDone | input | 1 | One-cycle pulse: general DMA ended its last cycle |
| cycleEnd | input | 1 | Current internal bus cycle completes this clock |
| busGrantN | input | 1 | External bus grant, active low, asynchronous |
| addrStrobeN | input | 1 | Address strobe, active low, asynchronous |
| haltN | input | 1 | Halt, active low, asynchronous |
| extAckN | input | 1 | Another master's grant acknowledge, active low, asynchronous |
| busReqN | output | 1 | Bus request to the outside bus, active low |
| busAckN | output | 1 | Own grant acknowledge, active low |
| grant | output | 3 | One-hot grant per requester |
| busOe | output | 1 | Bus output enable; low means the bus is high impedance |
| extOwner | output | 1 | Bus has been handed to the outside master after a halt |

## Verification
The owner's done pulse and an active halt can coincide in the same clock while another DMA request is waiting. The bench provokes this by holding haltN low long enough for the synchronizer, raising a second request, and then firing the general DMA's done pulse. The result is correct if the halt wins: the grant clears, it is not passed to the waiting engine, busOe drops, and extOwner rises later. A second collision tested is an outside-master request against both DMA requests at the same arbitration point.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NREQ     = 3;
  localparam int IDX_EXT  = 0;
  localparam int IDX_SDMA = 1;
  localparam int IDX_IDMA = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOCAL, ST_REQ, ST_FREEWAIT, ST_OWN, ST_HALTWAIT, ST_HCOUNT, ST_EXTOWN
  } arbState_t;

  typedef struct packed {
    logic winLoad;
    logic cntClr;
    logic cntInc;
  } dpStrobe_t;
endpackage

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CLKS   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            periphMode,
  input  logic            extMasterReq,
  input  logic            sdmaReq,
  input  logic            idmaReq,
  input  logic            sdmaDone,
  input  logic            idmaDone,
  input  logic            busGrantN,
  input  logic            addrStrobeN,
  input  logic            haltN,
  input  logic            extAckN,
  input  dpStrobe_t       strobe,
  output logic            grantSeen,
  output logic            asFree,
  output logic            haltOn,
  output logic            ackFree,
  output logic            anyReq,
  output logic            pickIsExt,
  output logic            winReqLive,
  output logic            ownerDone,
  output logic [NREQ-1:0] winVec,
  output logic            cntDone
);
  localparam int NPIN = 4;
  localparam int CW   = (HOLD_CLKS > 1) ? $clog2(HOLD_CLKS) : 1;

  // pin synchronizers, reset to the negated (high) level
  logic [NPIN-1:0] rawPins;
  logic [NPIN-1:0] syncQ [SYNC_STAGES];
  assign rawPins = {busGrantN, addrStrobeN, haltN, extAckN};

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= '1;
        else if (s == 0) syncQ[s] <= rawPins;
        else syncQ[s] <= syncQ[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign grantSeen = !syncQ[SYNC_STAGES-1][3];
  assign asFree    =  syncQ[SYNC_STAGES-1][2];
  assign haltOn    = !syncQ[SYNC_STAGES-1][1];
  assign ackFree   =  syncQ[SYNC_STAGES-1][0];

  // request ranking
  logic [NREQ-1:0] reqVec, doneVec, pick;
  assign reqVec  = {idmaReq, sdmaReq, extMasterReq & periphMode};
  assign doneVec = {idmaDone, sdmaDone, 1'b0};

  always_comb begin
    pick = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (reqVec[i]) pick = NREQ'(1) << i;
    end
  end

  assign anyReq    = |reqVec;
  assign pickIsExt = pick[IDX_EXT];

  always_ff @(posedge clk) begin
    if (!rstN) winVec <= '0;
    else if (strobe.winLoad) winVec <= pick;
  end

  assign winReqLive = |(reqVec & winVec);
  assign ownerDone  = |(doneVec & winVec);

  // post-strobe hold counter
  logic [CW-1:0] holdCnt;
  always_ff @(posedge clk) begin
    if (!rstN || strobe.cntClr) holdCnt <= '0;
    else if (strobe.cntInc) holdCnt <= holdCnt + 1'b1;
  end
  assign cntDone = (holdCnt == CW'(HOLD_CLKS - 1));

  a_r3_ext_masked: assert property (@(posedge clk) disable iff (!rstN)
    !periphMode |-> !winVec[IDX_EXT]);
  a_r2_winner_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(winVec));
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            periphMode,
  input  logic            cycleEnd,
  input  logic            grantSeen,
  input  logic            asFree,
  input  logic            haltOn,
  input  logic            ackFree,
  input  logic            anyReq,
  input  logic            pickIsExt,
  input  logic            winReqLive,
  input  logic            ownerDone,
  input  logic [NREQ-1:0] winVec,
  input  logic            cntDone,
  output dpStrobe_t       strobe,
  output logic            busReqN,
  output logic            busAckN,
  output logic [NREQ-1:0] grant,
  output logic            busOe,
  output logic            extOwner
);
  arbState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (!periphMode && haltOn) nextState = ST_HALTWAIT;
        else if (anyReq) begin
          strobe.winLoad = 1'b1;
          if (pickIsExt) nextState = ST_LOCAL;
          else if (periphMode) nextState = ST_REQ;
          else nextState = ST_OWN;
        end
      end
      ST_LOCAL:    if (!winReqLive) nextState = ST_IDLE;
      ST_REQ: begin
        if (!winReqLive) nextState = ST_IDLE;
        else if (grantSeen) nextState = ST_FREEWAIT;
      end
      ST_FREEWAIT: if (asFree && !haltOn && ackFree) nextState = ST_OWN;
      ST_OWN: begin
        if (!periphMode && haltOn && (cycleEnd || ownerDone)) nextState = ST_HALTWAIT;
        else if (ownerDone) nextState = ST_IDLE;
      end
      ST_HALTWAIT: begin
        strobe.cntClr = 1'b1;
        if (asFree) nextState = ST_HCOUNT;
      end
      ST_HCOUNT: begin
        if (!asFree) nextState = ST_HALTWAIT;
        else if (cntDone) nextState = ST_EXTOWN;
        else strobe.cntInc = 1'b1;
      end
      ST_EXTOWN:   if (!haltOn) nextState = ST_IDLE;
      default:     nextState = ST_IDLE;
    endcase
  end

  logic ownsExt;
  assign ownsExt  = (state == ST_OWN) && periphMode;
  assign busReqN  = !((state == ST_REQ) || (state == ST_FREEWAIT) || ownsExt);
  assign busAckN  = !ownsExt;
  assign grant    = ((state == ST_OWN) || (state == ST_LOCAL)) ? winVec : '0;
  assign extOwner = (state == ST_EXTOWN);
  assign busOe    = periphMode ? ownsExt
                  : !((state == ST_HALTWAIT) || (state == ST_HCOUNT) || (state == ST_EXTOWN));

  a_r5_ack_after_free: assert property (@(posedge clk) disable iff (!rstN)
    (!busAckN && $past(busAckN)) |-> $past(asFree && !haltOn && ackFree && grantSeen));
  a_r6_release: assert property (@(posedge clk) disable iff (!rstN)
    (periphMode && !busAckN && ownerDone) |=> (busAckN && busReqN));
  a_r7_no_switch: assert property (@(posedge clk) disable iff (!rstN)
    ((|grant) && $past(|grant)) |-> (grant == $past(grant)));
  a_r8_quiet_handover: assert property (@(posedge clk) disable iff (!rstN)
    extOwner |-> (grant == '0 && !busOe));
  a_r10_strobe_free: assert property (@(posedge clk) disable iff (!rstN)
    $rose(extOwner) |-> ($past(asFree) && $past(asFree, 2)));
endmodule

// File: rtl/bus_owner_arb.sv
module bus_owner_arb
  import arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CLKS   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            periphMode,
  input  logic            extMasterReq,
  input  logic            sdmaReq,
  input  logic            idmaReq,
  input  logic            sdmaDone,
  input  logic            idmaDone,
  input  logic            cycleEnd,
  input  logic            busGrantN,
  input  logic            addrStrobeN,
  input  logic            haltN,
  input  logic            extAckN,
  output logic            busReqN,
  output logic            busAckN,
  output logic [NREQ-1:0] grant,
  output logic            busOe,
  output logic            extOwner
);
  dpStrobe_t       strobe;
  logic            grantSeen, asFree, haltOn, ackFree;
  logic            anyReq, pickIsExt, winReqLive, ownerDone, cntDone;
  logic [NREQ-1:0] winVec;

  arb_datapath #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CLKS(HOLD_CLKS)) u_dp (
    .clk(clk), .rstN(rstN), .periphMode(periphMode),
    .extMasterReq(extMasterReq), .sdmaReq(sdmaReq), .idmaReq(idmaReq),
    .sdmaDone(sdmaDone), .idmaDone(idmaDone),
    .busGrantN(busGrantN), .addrStrobeN(addrStrobeN), .haltN(haltN), .extAckN(extAckN),
    .strobe(strobe), .grantSeen(grantSeen), .asFree(asFree), .haltOn(haltOn),
    .ackFree(ackFree), .anyReq(anyReq), .pickIsExt(pickIsExt),
    .winReqLive(winReqLive), .ownerDone(ownerDone), .winVec(winVec), .cntDone(cntDone)
  );

  arb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .periphMode(periphMode), .cycleEnd(cycleEnd),
    .grantSeen(grantSeen), .asFree(asFree), .haltOn(haltOn), .ackFree(ackFree),
    .anyReq(anyReq), .pickIsExt(pickIsExt), .winReqLive(winReqLive),
    .ownerDone(ownerDone), .winVec(winVec), .cntDone(cntDone),
    .strobe(strobe), .busReqN(busReqN), .busAckN(busAckN), .grant(grant),
    .busOe(busOe), .extOwner(extOwner)
  );

  a_r8_single_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));
endmodule

// File: tb/tb_bus_owner_arb.sv
module tb_bus_owner_arb;
  logic clk = 1'b0;
  logic rstN, periphMode, extMasterReq, sdmaReq, idmaReq, sdmaDone, idmaDone, cycleEnd;
  logic busGrantN, addrStrobeN, haltN, extAckN;
  logic busReqN, busAckN, busOe, extOwner;
  logic [2:0] grant;

  int checks = 0;
  int failures = 0;
  logic [2:0] expQ[$];
  logic [2:0] prevGrant = 3'b000;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_owner_arb dut (
    .clk(clk), .rstN(rstN), .periphMode(periphMode), .extMasterReq(extMasterReq),
    .sdmaReq(sdmaReq), .idmaReq(idmaReq), .sdmaDone(sdmaDone), .idmaDone(idmaDone),
    .cycleEnd(cycleEnd), .busGrantN(busGrantN), .addrStrobeN(addrStrobeN),
    .haltN(haltN), .extAckN(extAckN), .busReqN(busReqN), .busAckN(busAckN),
    .grant(grant), .busOe(busOe), .extOwner(extOwner)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: each fresh grant is compared against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && grant != 3'b000 && prevGrant == 3'b000) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL R8 actual=%0d expected=%0d (unexpected grant)", grant, 0);
      end else begin
        logic [2:0] e;
        e = expQ.pop_front();
        if (grant !== e) begin
          failures++;
          $display("FAIL R2 actual=%0d expected=%0d", grant, e);
        end
      end
    end
    prevGrant = grant;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectGrant(input logic [2:0] v);
    expQ.push_back(v);
  endtask

  task automatic doReset(input logic mode);
    rstN = 1'b0; periphMode = mode; extMasterReq = 0; sdmaReq = 0; idmaReq = 0;
    sdmaDone = 0; idmaDone = 0; cycleEnd = 0;
    busGrantN = 1; addrStrobeN = 1; haltN = 1; extAckN = 1;
    cyc(3);
    rstN = 1'b1;
    cyc(1);
  endtask

  task automatic waitGrant(input string req);
    int n = 0;
    while (grant == 3'b000 && n < 50) begin cyc(1); n++; end
    check(grant != 3'b000, req, grant, 1);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    doReset(1'b1);
    check(busReqN && busAckN && grant == 0 && !busOe && !extOwner, "R1",
          {busReqN, busAckN, grant, busOe, extOwner}, 7'b1100000);

    // R4/R5/R6/R7 peripheral handshake with serial DMA
    sdmaReq = 1;
    cyc(1);
    check(!busReqN, "R4 request", busReqN, 0);
    cyc(4);
    check(grant == 0 && busAckN, "R4 no grant before bus grant", grant, 0);
    addrStrobeN = 0; busGrantN = 0;
    cyc(6);
    check(grant == 0 && busAckN, "R5 wait for strobe", busAckN, 1);
    expectGrant(3'b010);
    addrStrobeN = 1;
    waitGrant("R5 grant");
    check(!busAckN && busOe && grant == 3'b010, "R5 ack", {busAckN, busOe, grant}, 5'b01010);
    idmaReq = 1;
    cyc(4);
    check(grant == 3'b010, "R7 no preempt", grant, 3'b010);
    expectGrant(3'b100);
    sdmaDone = 1; sdmaReq = 0;
    cyc(1);
    sdmaDone = 0;
    check(busAckN && busReqN && grant == 0 && !busOe, "R6 release",
          {busAckN, busReqN, grant, busOe}, 6'b110000);
    waitGrant("R7 next served");
    idmaDone = 1; idmaReq = 0;
    cyc(1);
    idmaDone = 0; busGrantN = 1;
    cyc(3);

    // R2 priority with all three pending
    doReset(1'b1);
    expectGrant(3'b001);
    extMasterReq = 1; sdmaReq = 1; idmaReq = 1;
    cyc(1);
    check(grant == 3'b001 && busReqN, "R2 outside master first", grant, 1);
    expectGrant(3'b010);
    extMasterReq = 0;
    cyc(2);
    busGrantN = 0;
    waitGrant("R2 serial DMA second");
    sdmaDone = 1; sdmaReq = 0; idmaReq = 0;
    cyc(1);
    sdmaDone = 0; busGrantN = 1;
    cyc(3);

    // R3 processor-enabled mode
    doReset(1'b0);
    expectGrant(3'b100);
    extMasterReq = 1; idmaReq = 1;
    cyc(1);
    check(grant == 3'b100 && busReqN, "R3 outside master ignored", grant, 4);
    sdmaReq = 1;
    cyc(3);
    check(grant == 3'b100, "R7 enabled no preempt", grant, 4);
    expectGrant(3'b010);
    idmaDone = 1; idmaReq = 0; extMasterReq = 0;
    cyc(1);
    idmaDone = 0;
    cyc(1);
    check(grant == 3'b010, "R7 serial served next", grant, 2);
    sdmaDone = 1; sdmaReq = 0;
    cyc(1);
    sdmaDone = 0;
    cyc(2);

    // R9/R10/R11 halt takeover
    expectGrant(3'b100);
    idmaReq = 1;
    cyc(2);
    addrStrobeN = 0; haltN = 0;
    cyc(6);
    check(grant == 3'b100 && busOe, "R9 owner finishes cycle", grant, 4);
    cycleEnd = 1; idmaReq = 0;
    cyc(1);
    cycleEnd = 0;
    check(grant == 0 && !busOe, "R9 stop at cycle end", {grant, busOe}, 0);
    cyc(6);
    check(!extOwner, "R10 strobe still active", extOwner, 0);
    addrStrobeN = 1;
    cyc(4);
    check(!extOwner, "R10 not before hold", extOwner, 0);
    cyc(1);
    check(extOwner && !busOe && grant == 0, "R10 handover", extOwner, 1);
    haltN = 1;
    cyc(3);
    check(!extOwner && busOe, "R11 resume", {extOwner, busOe}, 2'b01);

    // R8 done and halt in the same cycle, other request waiting
    expectGrant(3'b100);
    idmaReq = 1;
    cyc(2);
    haltN = 0;
    cyc(4);
    sdmaReq = 1;
    idmaDone = 1; idmaReq = 0;
    cyc(1);
    idmaDone = 0;
    check(grant == 0 && !busOe, "R8 halt wins over done", {grant, busOe}, 0);
    cyc(6);
    check(extOwner && grant == 0, "R8 no grant during takeover", {extOwner, grant}, 4'b1000);
    sdmaReq = 0;
    haltN = 1;
    cyc(5);
    check(expQ.size() == 0, "R2 scoreboard drained", expQ.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule